// File: doc/BRIEF.md
# External Bus Command Wait-State Controller

This block runs one external bus access at a time in the bus clock domain. It drives an active-low read or write command strobe and holds the command phase open until a programmed number of wait states has passed and, when handshake control is on, until the external device reports completion on its READY pin. When the access ends, the block raises a data-capture strobe for reads, releases the command strobe on the next edge and gives a one-clock completion pulse.

The settings are taken when a request is accepted and hold for that access: direction, wait-state count, whether READY ends the access, which pin level counts as active, and whether READY is used directly or through a two-flop synchronizer. Synchronous use gives the shortest access but needs a pin that meets setup to the clock. Asynchronous use accepts any pin timing and adds two clocks of latency from READY to termination.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While reset is asserted and right after it, rd_n_o and wr_n_o are 1 and capture_o and done_o are 0.
- R2: A request is taken only in the idle state. rw_i=1 selects a read (rd_n_o low), rw_i=0 a write (wr_n_o low). The strobe goes low on the edge that samples req_i=1, both strobes are never low together, and a request raised during an access is dropped.
- R3: The strobe stays low for at least two clocks and at least wait_cfg_i+2 clocks. The first READY sample is taken on the edge after wait_cfg_i wait states, never earlier.
- R4: READY is active when ready_pin_i equals rdy_pol_i (1 = active high, 0 = active low).
- R5: In synchronous mode (async_mode_i=0) with READY control on, a pin that becomes active before edge k ends the access at the first sample edge at or after k. With the pin active from the start, the strobe is low for exactly wait_cfg_i+2 clocks.
- R6: In asynchronous mode (async_mode_i=1), READY ends the access two edges later than it would in synchronous mode. With the pin active from the start, the strobe is low for max(wait_cfg_i+2, 4) clocks.
- R7: A READY pulse that covers at least one rising clock edge is recognised in both modes. A pulse that covers no rising edge has no effect.
- R8: READY seen while idle, or left active from the previous access, does not end a new access. In asynchronous mode the synchronizer is emptied while no command is active.
- R9: For a read, capture_o is high for exactly one clock, the last clock with rd_n_o low. It is never high during a write.
- R10: done_o is high for exactly one clock, the first clock after the strobe returns high.
- R11: With rdy_en_i=0, the strobe is low for exactly wait_cfg_i+2 clocks whatever ready_pin_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start an access (taken when idle) |
| rw_i | input | 1 | 1 = read, 0 = write |
| wait_cfg_i | input | WAIT_W | Command-phase wait states |
| rdy_en_i | input | 1 | 1 = READY ends the access |
| rdy_pol_i | input | 1 | Active level of the READY pin |
| async_mode_i | input | 1 | 1 = READY passes through the synchronizer |
| ready_pin_i | input | 1 | Raw READY pin |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| capture_o | output | 1 | Read data capture pulse |
| done_o | output | 1 | Access-complete pulse |

## Verification
The bench measures how long the strobe stays low for zero, small and large wait counts in both modes and with a READY that arrives late. A design that sampled READY before the wait states ran out, or skipped the synchronizer latency, would end accesses early. Sub-clock glitches, single-clock READY pulses and READY left active from the previous access check the recognition boundary: a design that latched glitches or kept stale synchronizer contents would end accesses at the wrong time. It also checks that a request raised mid-access is dropped, and that capture and done each pulse once at the right edge, since a design that restarted or repeated those pulses would show up on the ports.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_TERM   = 3'd3,
        ST_DONE   = 3'd4
    } cyc_state_e;

    function automatic logic strobe_phase(input cyc_state_e s);
        return (s == ST_CMD) || (s == ST_SAMPLE) || (s == ST_TERM);
    endfunction

endpackage

// File: rtl/xbus_rdy_front.sv
// READY front end: polarity correction and optional synchronizer chain.
module xbus_rdy_front #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    input  logic async_i,
    input  logic clear_i,
    output logic seen_o
);
    logic                  act;
    logic [SYNC_DEPTH-1:0] chain_d, chain_q, shifted;

    assign act = (pin_i == pol_i);

    generate
        if (SYNC_DEPTH == 1) begin : g_one
            assign shifted = act;
        end else begin : g_many
            assign shifted = {chain_q[SYNC_DEPTH-2:0], act};
        end
    endgenerate

    always_comb begin
        chain_d = clear_i ? '0 : shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign seen_o = async_i ? chain_q[SYNC_DEPTH-1] : act;

endmodule

// File: rtl/xbus_wait_cnt.sv
// Loadable down counter for command-phase wait states.
module xbus_wait_cnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] val_i,
    input  logic              dec_i,
    output logic              zero_o
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = val_i;
        else if (dec_i) cnt_d = cnt_q - WAIT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/xbus_cycle_seq.sv
// Access sequencer: idle -> command -> READY sampling -> terminate -> done.
module xbus_cycle_seq
    import xbus_wait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rw_i,
    input  logic rdy_en_i,
    input  logic rdy_pol_i,
    input  logic async_i,
    input  logic cnt_zero_i,
    input  logic seen_i,
    output logic cnt_load_o,
    output logic cnt_dec_o,
    output logic pol_o,
    output logic async_o,
    output logic clear_o,
    output logic rd_n_o,
    output logic wr_n_o,
    output logic capture_o,
    output logic done_o
);
    typedef struct packed {
        cyc_state_e state;
        logic       is_read;
        logic       rdy_en;
        logic       pol;
        logic       asyn;
        logic       rd_n;
        logic       wr_n;
        logic       capture;
        logic       done;
    } seq_t;

    seq_t s_d, s_q;
    logic active_d;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.state   = ST_CMD;
                    s_d.is_read = rw_i;
                    s_d.rdy_en  = rdy_en_i;
                    s_d.pol     = rdy_pol_i;
                    s_d.asyn    = async_i;
                end
            end
            ST_CMD: begin
                if (cnt_zero_i) begin
                    if (!s_q.rdy_en || seen_i) s_d.state = ST_TERM;
                    else                       s_d.state = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (seen_i) s_d.state = ST_TERM;
            end
            ST_TERM: s_d.state = ST_DONE;
            ST_DONE: s_d.state = ST_IDLE;
            default: s_d.state = ST_IDLE;
        endcase

        active_d    = strobe_phase(s_d.state);
        s_d.rd_n    = !(active_d &&  s_d.is_read);
        s_d.wr_n    = !(active_d && !s_d.is_read);
        s_d.capture = (s_d.state == ST_TERM) && s_d.is_read;
        s_d.done    = (s_d.state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.state   <= ST_IDLE;
            s_q.rd_n    <= 1'b1;
            s_q.wr_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_load_o = (s_q.state == ST_IDLE) && req_i;
    assign cnt_dec_o  = (s_q.state == ST_CMD) && !cnt_zero_i;
    assign clear_o    = !strobe_phase(s_q.state);
    assign pol_o      = s_q.pol;
    assign async_o    = s_q.asyn;
    assign rd_n_o     = s_q.rd_n;
    assign wr_n_o     = s_q.wr_n;
    assign capture_o  = s_q.capture;
    assign done_o     = s_q.done;

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
    parameter int WAIT_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rw_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    input  logic              rdy_en_i,
    input  logic              rdy_pol_i,
    input  logic              async_mode_i,
    input  logic              ready_pin_i,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              capture_o,
    output logic              done_o
);
    logic cnt_load, cnt_dec, cnt_zero;
    logic seen, pol_l, async_l, clear;

    xbus_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (wait_cfg_i),
        .dec_i  (cnt_dec),
        .zero_o (cnt_zero)
    );

    xbus_rdy_front #(.SYNC_DEPTH(SYNC_DEPTH)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ready_pin_i),
        .pol_i   (pol_l),
        .async_i (async_l),
        .clear_i (clear),
        .seen_o  (seen)
    );

    xbus_cycle_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .rw_i       (rw_i),
        .rdy_en_i   (rdy_en_i),
        .rdy_pol_i  (rdy_pol_i),
        .async_i    (async_mode_i),
        .cnt_zero_i (cnt_zero),
        .seen_i     (seen),
        .cnt_load_o (cnt_load),
        .cnt_dec_o  (cnt_dec),
        .pol_o      (pol_l),
        .async_o    (async_l),
        .clear_o    (clear),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .capture_o  (capture_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic capture_o,
    input logic done_o
);
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    p_rd_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(req_i));

    p_wr_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(req_i));

    p_rd_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |=> !rd_n_o);

    p_wr_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |=> !wr_n_o);

    p_capture_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> (!rd_n_o && wr_n_o));

    p_capture_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> (!capture_o && rd_n_o));

    p_done_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_n_o && wr_n_o && (!$past(rd_n_o) || !$past(wr_n_o))));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .capture_o (capture_o),
    .done_o    (done_o)
);

// File: tb/tb_xbus_wait_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_wait_ctrl;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, rw = 1'b0, en = 1'b0, pol = 1'b1, asyn = 1'b0;
    logic rdy_pin = 1'b0;
    logic [WW-1:0] wcfg = '0;
    logic rd_n, wr_n, cap, done;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    xbus_wait_ctrl #(.WAIT_W(WW), .SYNC_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rw_i(rw), .wait_cfg_i(wcfg),
        .rdy_en_i(en), .rdy_pol_i(pol), .async_mode_i(asyn), .ready_pin_i(rdy_pin),
        .rd_n_o(rd_n), .wr_n_o(wr_n), .capture_o(cap), .done_o(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 waiting, 2 polling, 3 last, 4 finished
    int m_st = 0, m_left = 0;
    bit m_rw, m_en, m_pol, m_as, m_act, m_sn;
    bit hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            hist.delete();
        end else begin
            m_act = (rdy_pin == m_pol);
            m_sn  = m_as ? (hist.size() == 2 ? hist[0] : 1'b0) : m_act;
            if (m_st >= 1 && m_st <= 3) begin
                hist.push_back(m_act);
                if (hist.size() > 2) void'(hist.pop_front());
            end else begin
                hist.delete();
            end
            case (m_st)
                0: if (req) begin
                    m_st = 1; m_rw = rw; m_en = en; m_pol = pol; m_as = asyn;
                    m_left = int'(wcfg);
                end
                1: begin
                    if (m_left > 0) m_left--;
                    else if (!m_en || m_sn) m_st = 3;
                    else m_st = 2;
                end
                2: if (m_sn) m_st = 3;
                3: m_st = 4;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit on;
            on = (m_st >= 1 && m_st <= 3);
            chk(rd_n == !(on && m_rw),  "R3 model rd_n", rd_n, !(on && m_rw));
            chk(wr_n == !(on && !m_rw), "R3 model wr_n", wr_n, !(on && !m_rw));
            chk(cap == (m_st == 3 && m_rw), "R9 model capture", cap, (m_st == 3 && m_rw));
            chk(done == (m_st == 4), "R10 model done", done, (m_st == 4));
        end
    end

    // One access; len = clocks with the strobe low.
    task automatic run_cyc(input string tag, input bit r, input int w, input bit e,
                           input bit p, input bit a, input int d, input bit one,
                           input bit stale, input bit glitch, input bit busy,
                           input int exp_len);
        int len = 0, caps = 0, cap_k = -1;
        @(negedge clk);
        rw = r; wcfg = WW'(w); en = e; pol = p; asyn = a; req = 1'b1;
        rdy_pin = stale ? p : ~p;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (r ? rd_n : wr_n) break;
            len++;
            if (cap) begin caps++; cap_k = k; end
            rdy_pin = one ? ((k == d) ? p : ~p) : ((k >= d) ? p : ~p);
            if (busy) req = (k == 1);
            if (glitch && k == 1) begin
                fork
                    begin
                        @(posedge clk); #3 rdy_pin = p; #5 rdy_pin = ~p;
                    end
                join_none
            end
            @(negedge clk);
        end
        rdy_pin = ~p;
        req = 1'b0;
        chk(len == exp_len, {tag, " strobe length"}, len, exp_len);
        chk(caps == (r ? 1 : 0), "R9 capture count", caps, r ? 1 : 0);
        if (r) chk(cap_k == len - 1, "R9 capture on last strobe clock", cap_k, len - 1);
        chk(done == 1'b1, "R10 done after strobe rise", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single clock", done, 0);
        if (busy) begin
            for (int j = 0; j < 3; j++) begin
                chk(rd_n && wr_n, "R2 busy request dropped", {rd_n, wr_n}, 3);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_n && wr_n, "R1 reset strobes", {rd_n, wr_n}, 3);
        chk(!cap && !done, "R1 reset pulses", {cap, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_n && wr_n && !cap && !done, "R1 after reset", {rd_n, wr_n, cap, done}, 12);

        //        tag    rw w  en p  as d    one st gl busy len
        run_cyc("R5 a", 1, 0, 1, 1, 0, 0,    0, 0, 0, 0, 2);
        run_cyc("R5 b", 0, 3, 1, 1, 0, 0,    0, 0, 0, 0, 5);
        run_cyc("R5 c", 1, 1, 1, 1, 0, 5,    0, 0, 0, 0, 7);
        run_cyc("R11 a", 0, 2, 0, 1, 0, 1000, 0, 0, 0, 0, 4);
        run_cyc("R11 b", 1, 2, 0, 1, 0, 0,   0, 0, 0, 0, 4);
        run_cyc("R4 a", 1, 0, 1, 0, 0, 2,    0, 0, 0, 0, 4);
        run_cyc("R6 a", 1, 0, 1, 1, 1, 0,    0, 0, 0, 0, 4);
        run_cyc("R6 b", 0, 5, 1, 1, 1, 0,    0, 0, 0, 0, 7);
        run_cyc("R6 c", 1, 0, 1, 1, 1, 3,    0, 0, 0, 0, 7);
        run_cyc("R4 b", 1, 1, 1, 0, 1, 1,    0, 0, 0, 0, 5);
        run_cyc("R7 a", 1, 0, 1, 1, 1, 2,    1, 0, 0, 0, 6);
        run_cyc("R7 b", 1, 0, 1, 1, 1, 8,    1, 0, 1, 0, 12);
        run_cyc("R7 c", 0, 0, 1, 1, 0, 2,    1, 0, 0, 0, 4);
        run_cyc("R7 d", 1, 0, 1, 1, 0, 5,    1, 0, 1, 0, 7);
        run_cyc("R8 a", 1, 0, 1, 1, 1, 6,    0, 1, 0, 0, 10);
        run_cyc("R8 b", 0, 2, 1, 0, 0, 3,    0, 1, 0, 0, 5);
        run_cyc("R2 a", 0, 2, 0, 1, 0, 1000, 0, 0, 0, 1, 4);
        run_cyc("R3 a", 1, 15, 0, 1, 0, 0,   0, 0, 0, 0, 17);

        // R8: READY active while idle must not start or end anything
        rdy_pin = 1'b1; pol = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(rd_n && wr_n && !done, "R8 idle READY ignored", {rd_n, wr_n, done}, 6);
        end
        rdy_pin = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule